// File: doc/BRIEF.md
# Legacy NMI Gate with Index, Data and Control Ports

This block merges two error sources, a memory parity fault and a bus channel-check fault, into one level non-maskable interrupt line toward the processor. Each source has an enable bit and a sticky status bit in a byte-wide system control port. A separate write-only index port holds a global NMI mask in its top bit and a 7-bit index into a small byte array in its lower bits. A companion data port reads or writes the byte that the index selects.

Software reaches the block over a plain byte I/O bus: an address, a write strobe, a read strobe and a data byte each way. Each index write opens a sequence that an access to the data port must close. The block shows an open sequence on a pending flag. It sets a sticky protocol-error flag if a second index write arrives while the sequence is still open. The error inputs are one-cycle pulses.

Top module: `nmi_gate_top`

## Requirements
- R1: After reset the NMI mask is 1, both enables, both status bits and the storage bits of the control port are 0, and nmi_o, seq_pend_o and proto_err_o are 0, so a read of the control port (0x61) returns 0x00.
- R2: A write to the index port (0x70) loads bit 7 as the NMI mask (1 blocks, 0 allows) and bits 6:0 as the array index, both in the same write.
- R3: A read of the index port returns 0xFF whatever the mask and index hold.
- R4: A write to the index port sets seq_pend_o in the next cycle. A read or write of the data port (0x71) clears it in the next cycle.
- R5: An index-port write while seq_pend_o is 1 sets proto_err_o, and proto_err_o stays 1 until reset.
- R6: A data-port write stores the byte at the current index, and a data-port read returns it. The index wraps modulo RAM_WORDS (default 16, so index 0x13 selects word 3). Read data from any port appears on io_rdata in the cycle after the read strobe.
- R7: Control port bit 2 enables parity NMIs and bit 3 enables channel-check NMIs. A par_err_i pulse sets status bit 7, and a chk_err_i pulse sets status bit 6, only while the matching enable is 1. A pulse with the enable at 0 leaves the status bit at 0.
- R8: nmi_o is 1 exactly when at least one status bit is 1 and the mask is 0.
- R9: Writing 0 to an enable bit clears its status bit. The clear takes priority over an error pulse in the same cycle.
- R10: Host writes to control bits 6 and 7 are ignored. Bits 0, 1, 4 and 5 are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after io_rd |
| par_err_i | input | 1 | Memory parity error pulse |
| chk_err_i | input | 1 | Bus channel-check error pulse |
| nmi_o | output | 1 | Level NMI to the processor |
| seq_pend_o | output | 1 | Index written, data port not yet accessed |
| proto_err_o | output | 1 | Sticky double-index-write flag |

## Verification
Every register update (mask, index, enables, status, pending and protocol flags) takes effect at the clock edge that samples the strobe or pulse. nmi_o follows those registers without a further register, so it is due in the same cycle. Read data is registered and is due one cycle after io_rd. The bench drives each strobe or pulse on a falling edge and samples on the next falling edge, exactly one rising edge later, which matches all of these latencies.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
   localparam int BYTE_W     = 8;
   localparam int MASK_BIT   = 7;
   localparam int PAR_EN_BIT = 2;
   localparam int CHK_EN_BIT = 3;
   localparam int CHK_ST_BIT = 6;
   localparam int PAR_ST_BIT = 7;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/nmi_idx_port.sv
module nmi_idx_port
   import nmi_gate_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_wr,
   input  logic             dat_acc,
   input  byte_t            wdata,
   output logic             mask_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             pend_o,
   output logic             proto_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o  <= 1'b1;
         idx_o   <= '0;
         pend_o  <= 1'b0;
         proto_o <= 1'b0;
      end else begin
         if (idx_wr) begin
            mask_o <= wdata[MASK_BIT];
            idx_o  <= wdata[IDX_W-1:0];
            pend_o <= 1'b1;
            if (pend_o) proto_o <= 1'b1;
         end else if (dat_acc) begin
            pend_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nmi_ctl_port.sv
module nmi_ctl_port
   import nmi_gate_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ctl_wr,
   input  byte_t wdata,
   input  logic  par_pulse,
   input  logic  chk_pulse,
   output byte_t ctl_o,
   output logic  par_en_o,
   output logic  chk_en_o,
   output logic  par_st_o,
   output logic  chk_st_o
);
   logic [3:0] store_q;
   logic       par_clr, chk_clr;
   logic       unused_ro;

   assign unused_ro = ^wdata[PAR_ST_BIT:CHK_ST_BIT];
   assign par_clr   = ctl_wr && !wdata[PAR_EN_BIT];
   assign chk_clr   = ctl_wr && !wdata[CHK_EN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q  <= '0;
         par_en_o <= 1'b0;
         chk_en_o <= 1'b0;
         par_st_o <= 1'b0;
         chk_st_o <= 1'b0;
      end else begin
         if (ctl_wr) begin
            store_q  <= {wdata[5:4], wdata[1:0]};
            par_en_o <= wdata[PAR_EN_BIT];
            chk_en_o <= wdata[CHK_EN_BIT];
         end
         if (par_clr)                   par_st_o <= 1'b0;
         else if (par_en_o && par_pulse) par_st_o <= 1'b1;
         if (chk_clr)                   chk_st_o <= 1'b0;
         else if (chk_en_o && chk_pulse) chk_st_o <= 1'b1;
      end
   end

   always_comb begin
      ctl_o             = {2'b00, store_q[3:2], 2'b00, store_q[1:0]};
      ctl_o[PAR_EN_BIT] = par_en_o;
      ctl_o[CHK_EN_BIT] = chk_en_o;
      ctl_o[PAR_ST_BIT] = par_st_o;
      ctl_o[CHK_ST_BIT] = chk_st_o;
   end
endmodule

// File: rtl/nmi_data_ram.sv
module nmi_data_ram
   import nmi_gate_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  byte_t            wdata,
   output byte_t            rdata
);
   localparam int AW = $clog2(WORDS);

   byte_t          mem [WORDS];
   logic  [AW-1:0] sel;

   assign sel = idx[AW-1:0];

   generate
      if (AW < IDX_W) begin : g_wrap
         logic unused_hi;
         assign unused_hi = ^idx[IDX_W-1:AW];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (wr) begin
         mem[sel] <= wdata;
      end
   end

   assign rdata = mem[sel];
endmodule

// File: rtl/nmi_gate_top.sv
module nmi_gate_top
   import nmi_gate_pkg::*;
#(
   parameter int          RAM_WORDS = 16,
   parameter int          IDX_W     = 7,
   parameter bit          RDATA_REG = 1'b1,
   parameter logic [7:0]  IDX_ADDR  = 8'h70,
   parameter logic [7:0]  DAT_ADDR  = 8'h71,
   parameter logic [7:0]  CTL_ADDR  = 8'h61
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] io_addr,
   input  logic       io_wr,
   input  logic       io_rd,
   input  logic [7:0] io_wdata,
   output logic [7:0] io_rdata,
   input  logic       par_err_i,
   input  logic       chk_err_i,
   output logic       nmi_o,
   output logic       seq_pend_o,
   output logic       proto_err_o
);
   generate
      if (RAM_WORDS < 2 || RAM_WORDS > (1 << IDX_W) ||
          (RAM_WORDS & (RAM_WORDS - 1)) != 0) begin : g_bad_words
         $error("RAM_WORDS must be a power of two within the index range");
      end
      if (IDX_W < 1 || IDX_W > MASK_BIT) begin : g_bad_idx
         $error("IDX_W must fit below the mask bit");
      end
   endgenerate

   logic             hit_idx, hit_dat, hit_ctl;
   logic             mask, par_en, chk_en, par_st, chk_st;
   logic [IDX_W-1:0] idx;
   byte_t            ctl_byte, ram_byte, rd_mux;

   assign hit_idx = io_addr == IDX_ADDR;
   assign hit_dat = io_addr == DAT_ADDR;
   assign hit_ctl = io_addr == CTL_ADDR;

   nmi_idx_port #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(io_wr && hit_idx),
      .dat_acc((io_wr || io_rd) && hit_dat),
      .wdata(io_wdata),
      .mask_o(mask), .idx_o(idx), .pend_o(seq_pend_o), .proto_o(proto_err_o)
   );

   nmi_ctl_port u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(io_wr && hit_ctl), .wdata(io_wdata),
      .par_pulse(par_err_i), .chk_pulse(chk_err_i),
      .ctl_o(ctl_byte),
      .par_en_o(par_en), .chk_en_o(chk_en),
      .par_st_o(par_st), .chk_st_o(chk_st)
   );

   nmi_data_ram #(.WORDS(RAM_WORDS), .IDX_W(IDX_W)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .wr(io_wr && hit_dat), .idx(idx),
      .wdata(io_wdata), .rdata(ram_byte)
   );

   always_comb begin
      if (hit_idx)      rd_mux = 8'hFF;
      else if (hit_dat) rd_mux = ram_byte;
      else if (hit_ctl) rd_mux = ctl_byte;
      else              rd_mux = 8'h00;
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n)     io_rdata <= '0;
            else if (io_rd) io_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign io_rdata = io_rd ? rd_mux : 8'h00;
      end
   endgenerate

   assign nmi_o = (par_st || chk_st) && !mask;
endmodule

// File: rtl/nmi_gate_chk.sv
module nmi_gate_chk #(
   parameter bit         RDATA_REG = 1'b1,
   parameter logic [7:0] IDX_ADDR  = 8'h70,
   parameter logic [7:0] DAT_ADDR  = 8'h71,
   parameter logic [7:0] CTL_ADDR  = 8'h61
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] io_addr,
   input logic       io_wr,
   input logic       io_rd,
   input logic [7:0] io_wdata,
   input logic [7:0] io_rdata,
   input logic       par_err_i,
   input logic       nmi_o,
   input logic       seq_pend_o,
   input logic       proto_err_o,
   input logic       mask,
   input logic       par_en,
   input logic       par_st
);
   // R4
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == IDX_ADDR) |=> seq_pend_o);
   // R4
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_wr || io_rd) && io_addr == DAT_ADDR) |=> !seq_pend_o);
   // R5
   proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o);
   // R5
   proto_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == IDX_ADDR && seq_pend_o) |=> proto_err_o);
   // R8
   mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask |-> !nmi_o);
   // R7
   par_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err_i && par_en && !(io_wr && io_addr == CTL_ADDR)) |=> par_st);
   // R9
   par_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == CTL_ADDR && !io_wdata[2]) |=> !par_st);
   // R3
   idx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (RDATA_REG && io_rd && io_addr == IDX_ADDR) |=> io_rdata == 8'hFF);
endmodule

bind nmi_gate_top nmi_gate_chk #(
   .RDATA_REG(RDATA_REG), .IDX_ADDR(IDX_ADDR),
   .DAT_ADDR(DAT_ADDR), .CTL_ADDR(CTL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
   .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
   .par_err_i(par_err_i), .nmi_o(nmi_o), .seq_pend_o(seq_pend_o),
   .proto_err_o(proto_err_o), .mask(mask), .par_en(par_en), .par_st(par_st)
);

// File: tb/tb_nmi_gate_top.sv
`timescale 1ns/1ps
module tb_nmi_gate_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = '0;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic       par_err_i = 1'b0;
   logic       chk_err_i = 1'b0;
   logic       nmi_o, seq_pend_o, proto_err_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   nmi_gate_top dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .par_err_i(par_err_i), .chk_err_i(chk_err_i), .nmi_o(nmi_o),
      .seq_pend_o(seq_pend_o), .proto_err_o(proto_err_o)
   );

   // {is_read, addr, wdata, expected}
   localparam int NV = 16;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 8'h61, 8'h00, 8'h00},  // R1 control reads zero
      {1'b1, 8'h70, 8'h00, 8'hFF},  // R3
      {1'b0, 8'h70, 8'h03, 8'h00},  // R2 mask 0, index 3
      {1'b0, 8'h71, 8'hA5, 8'h00},  // R6
      {1'b0, 8'h70, 8'h04, 8'h00},
      {1'b0, 8'h71, 8'h3C, 8'h00},
      {1'b0, 8'h70, 8'h83, 8'h00},  // R2 mask 1, index 3
      {1'b1, 8'h71, 8'h00, 8'hA5},  // R6
      {1'b0, 8'h70, 8'h84, 8'h00},
      {1'b1, 8'h71, 8'h00, 8'h3C},  // R6
      {1'b0, 8'h70, 8'h93, 8'h00},  // index 0x13 wraps to 3
      {1'b1, 8'h71, 8'h00, 8'hA5},  // R6 wrap
      {1'b0, 8'h61, 8'hFF, 8'h00},
      {1'b1, 8'h61, 8'h00, 8'h3F},  // R10 status bits ignored
      {1'b0, 8'h61, 8'hF3, 8'h00},
      {1'b1, 8'h61, 8'h00, 8'h33}   // R10 storage bits
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   task automatic pulse(input bit par, input bit ch);
      @(negedge clk);
      par_err_i = par; chk_err_i = ch;
      @(negedge clk);
      par_err_i = 1'b0; chk_err_i = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 nmi", {7'b0, nmi_o}, 8'h00);
      chk("R1 pend", {7'b0, seq_pend_o}, 8'h00);
      chk("R1 proto", {7'b0, proto_err_o}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) begin
            rd(VEC[i][23:16], d);
            chk($sformatf("R6/R10 vec%0d", i), d, VEC[i][7:0]);
         end else begin
            wr(VEC[i][23:16], VEC[i][15:8]);
         end
      end
      chk("R4 closed", {7'b0, seq_pend_o}, 8'h00);
      chk("R5 none", {7'b0, proto_err_o}, 8'h00);

      // R7 disabled source does not latch
      pulse(1, 1);
      rd(8'h61, d); chk("R7 disabled", d, 8'h33);
      chk("R7 nmi", {7'b0, nmi_o}, 8'h00);

      // R7 enabled parity latches, masked (R8)
      wr(8'h61, 8'h0C);
      pulse(1, 0);
      rd(8'h61, d); chk("R7 parity", d, 8'h8C);
      chk("R8 masked", {7'b0, nmi_o}, 8'h00);
      wr(8'h70, 8'h00);
      chk("R8 unmasked", {7'b0, nmi_o}, 8'h01);
      chk("R4 pend", {7'b0, seq_pend_o}, 8'h01);
      rd(8'h71, d);
      chk("R4 cleared", {7'b0, seq_pend_o}, 8'h00);
      rd(8'h70, d); chk("R3 readback", d, 8'hFF);

      pulse(0, 1);
      rd(8'h61, d); chk("R7 channel", d, 8'hCC);

      // R9 clear by writing enable 0
      wr(8'h61, 8'h08);
      rd(8'h61, d); chk("R9 par clear", d, 8'h48);
      chk("R8 chan only", {7'b0, nmi_o}, 8'h01);
      wr(8'h61, 8'h00);
      rd(8'h61, d); chk("R9 both clear", d, 8'h00);
      chk("R8 idle", {7'b0, nmi_o}, 8'h00);

      // R9 clear wins over a same-cycle pulse
      wr(8'h61, 8'h04);
      @(negedge clk);
      io_addr = 8'h61; io_wdata = 8'h00; io_wr = 1'b1; par_err_i = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; par_err_i = 1'b0;
      rd(8'h61, d); chk("R9 priority", d, 8'h00);

      // R5 double index write
      wr(8'h70, 8'h80);
      chk("R5 first", {7'b0, proto_err_o}, 8'h00);
      wr(8'h70, 8'h80);
      chk("R5 second", {7'b0, proto_err_o}, 8'h01);
      wr(8'h71, 8'h11);
      chk("R4 data wr", {7'b0, seq_pend_o}, 8'h00);
      chk("R5 sticky", {7'b0, proto_err_o}, 8'h01);

      summary();
   end
endmodule